// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host end of a two-wire serial programming link: one clock line that the host always drives, and one data line whose direction it turns around. Operations come in on a valid/ready request port. Each request carries a 3-bit operation code and a 14-bit write value. The block turns each request into a 6-bit command frame, an optional 16-cycle data frame and the wait periods the target needs. Read results come back on a one-cycle strobe.

Bits go out least significant first. The host changes the data line when it raises the serial clock, and the target latches the bit when the clock falls. The serial clock half-period and every wait are parameters counted in system clocks. There are three kinds of wait: the command-to-data gap, the short gap after a transfer, and the long waits after ending a program cycle and after a bulk erase. Two erase recipes are built in. The first is a single bulk erase followed by the erase wait. The second first loads the configuration pointer with zero data, then does the bulk erase and the erase wait.

Top module: `pgm_host_seq`

## Requirements
- R1: Each operation starts with a command frame of exactly 6 serial clock pulses carrying a 6-bit code, least significant bit first. The codes (MSb..LSb) are: op 0 load configuration 000000, op 1 load program data 000010, op 2 read program data 000100, op 3 advance address 000110, op 4 start programming 001000, op 5 finish programming 001010, op 6 and op 7 bulk erase 001001.
- R2: Ops 0 and 1 follow the command with a 16-pulse data frame. The frame is a 0 start bit, the 14-bit write value least significant bit first, then a 0 stop bit, all driven by the host.
- R3: The data line only changes while the serial clock is low or as the clock rises. Its value is held unchanged from the rising edge through the falling edge of each pulse.
- R4: Before the first pulse of a data frame, the serial clock stays low for at least T_CD system clocks after the last command pulse falls.
- R5: For op 2, the host releases the data line (output enable low) for the whole 16-pulse frame. It samples one bit in each of pulses 2 to 15 while the clock is high. It then returns the 14-bit value on rd_data with rd_valid high for exactly one cycle, while busy is still high.
- R6: After every transfer, the clock stays low for at least T_CC system clocks before the next command pulse or before the block becomes ready. After op 5 this low time is at least T_END.
- R7: Op 6 sends one bulk erase command. The clock then stays low for at least T_ERA system clocks before ready returns.
- R8: Op 7 sends a load configuration command with an all-zero data frame, then a bulk erase command, then holds the clock low for at least T_ERA before ready returns.
- R9: req_ready is high only when idle. A request presented while busy is not accepted and produces no frame.
- R10: After reset, busy is low, req_ready is high and the serial clock, data line and enable are low. busy rises in the cycle after a request is accepted and stays high until the final wait has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 3 | Operation code (see R1, R7, R8) |
| req_wdata | input | 14 | Write value for load operations |
| rd_valid | output | 1 | One-cycle strobe with read result |
| rd_data | output | 14 | Read result |
| busy | output | 1 | Operation in progress, including waits |
| pgm_clk | output | 1 | Serial clock to target |
| pgm_dat_o | output | 1 | Serial data driven by host |
| pgm_dat_oe | output | 1 | High while host drives the data line |
| pgm_dat_i | input | 1 | Serial data from the data line |

## Verification
The bench builds the block with a half-period of 2 system clocks, T_CD = 6, T_CC = 5, T_END = 30 and T_ERA = 60. With these values the long end-of-program and erase waits finish in tens of cycles, so dozens of random operations fit in a short run. The waits also stay far enough apart from the short gaps that a wait taken from the wrong parameter falls below the checked minimum. With a two-cycle half-period, the sampling point and the data hold across the falling edge each land on a distinct cycle, so those timing points can be observed separately.

// File: rtl/pgm_pkg.sv
// Shared definitions for the serial programming host sequencer.
// Assumes 6-bit command codes decoded by the target exactly as listed.
package pgm_pkg;

    localparam int CMD_W = 6;

    localparam logic [CMD_W-1:0] CMD_LOAD_CFG   = 6'b000000;
    localparam logic [CMD_W-1:0] CMD_LOAD_PGM   = 6'b000010;
    localparam logic [CMD_W-1:0] CMD_READ_PGM   = 6'b000100;
    localparam logic [CMD_W-1:0] CMD_NEXT_ADR   = 6'b000110;
    localparam logic [CMD_W-1:0] CMD_START_PRG  = 6'b001000;
    localparam logic [CMD_W-1:0] CMD_FINISH_PRG = 6'b001010;
    localparam logic [CMD_W-1:0] CMD_BULK_ERASE = 6'b001001;

    typedef enum logic [2:0] {
        OP_LOAD_CFG   = 3'd0,
        OP_LOAD_PGM   = 3'd1,
        OP_READ_PGM   = 3'd2,
        OP_NEXT_ADR   = 3'd3,
        OP_START_PRG  = 3'd4,
        OP_FINISH_PRG = 3'd5,
        OP_ERASE_ONE  = 3'd6,
        OP_ERASE_CFG  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_CDGAP,
        ST_DATA,
        ST_TAIL
    } st_e;

    // First command sent for an operation.
    function automatic logic [CMD_W-1:0] first_cmd(input logic [2:0] op);
        case (op)
            OP_LOAD_CFG:   return CMD_LOAD_CFG;
            OP_LOAD_PGM:   return CMD_LOAD_PGM;
            OP_READ_PGM:   return CMD_READ_PGM;
            OP_NEXT_ADR:   return CMD_NEXT_ADR;
            OP_START_PRG:  return CMD_START_PRG;
            OP_FINISH_PRG: return CMD_FINISH_PRG;
            OP_ERASE_ONE:  return CMD_BULK_ERASE;
            default:       return CMD_LOAD_CFG;
        endcase
    endfunction

    // True for commands followed by a 16-pulse data frame.
    function automatic logic has_data(input logic [CMD_W-1:0] c);
        return (c == CMD_LOAD_CFG) || (c == CMD_LOAD_PGM) || (c == CMD_READ_PGM);
    endfunction

    // True when the data frame is driven by the target.
    function automatic logic is_read(input logic [CMD_W-1:0] c);
        return c == CMD_READ_PGM;
    endfunction

endpackage

// File: rtl/pgm_bit_shifter.sv
// Serial bit engine: emits NBITS clock pulses of 2*HALF system clocks each
// (high half first), presents tx bits LSb first from the rising edge, and in
// listen mode releases the line and captures bits 2..N-1 of the frame at the
// end of each high half. Assumes start is only pulsed while idle.
module pgm_bit_shifter #(
    parameter int HALF    = 4,
    parameter int FRAME_W = 16,
    parameter int RX_W    = 14,
    localparam int CW     = $clog2(FRAME_W + 1),
    localparam int PW     = $clog2(2 * HALF) < 1 ? 1 : $clog2(2 * HALF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CW-1:0]      nbits,
    input  logic [FRAME_W-1:0] tx,
    input  logic               listen,
    input  logic               dat_i,
    output logic               done,
    output logic [RX_W-1:0]    rx,
    output logic               sclk,
    output logic               dat_o,
    output logic               dat_oe
);
    localparam logic [PW-1:0] PH_HI_END = PW'(HALF - 1);
    localparam logic [PW-1:0] PH_LAST   = PW'(2 * HALF - 1);

    logic               active;
    logic               listen_q;
    logic [PW-1:0]      ph;
    logic [CW-1:0]      left;
    logic [FRAME_W-1:0] sh;
    logic               first_q;

    // Phase, bit count, transmit shift and receive capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            listen_q <= 1'b0;
            ph       <= '0;
            left     <= '0;
            sh       <= '0;
            rx       <= '0;
            done     <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active   <= 1'b1;
                listen_q <= listen;
                ph       <= '0;
                left     <= nbits;
                sh       <= tx;
                first_q  <= 1'b1;
            end else if (active) begin
                if (listen_q && ph == PH_HI_END && !first_q && left != CW'(1))
                    rx <= {dat_i, rx[RX_W-1:1]};
                if (ph == PH_LAST) begin
                    ph      <= '0;
                    sh      <= sh >> 1;
                    left    <= left - CW'(1);
                    first_q <= 1'b0;
                    if (left == CW'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end else begin
                    ph <= ph + PW'(1);
                end
            end
        end
    end

    // Line outputs derived from the engine state.
    always_comb begin
        sclk   = active && (ph <= PH_HI_END);
        dat_oe = active && !listen_q;
        dat_o  = active && !listen_q && sh[0];
    end

endmodule

// File: rtl/pgm_gap_timer.sv
// Down-counting wait timer: after a load pulse with value N it raises done for
// one cycle roughly N cycles later (at least N). Assumes load only when idle.
module pgm_gap_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          done
);
    logic [TW-1:0] cnt;
    logic          run;

    // Count the loaded interval down and flag its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                cnt <= val;
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= TW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - TW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pgm_host_seq.sv
// Host sequencer for the two-wire programming link. Accepts one operation at
// a time, sends command and data frames through the bit engine and inserts the
// command-dependent waits through the gap timer. The two erase recipes are
// chained command steps. Assumes the target follows the listed command codes.
module pgm_host_seq #(
    parameter int HALF   = 4,
    parameter int DATA_W = 14,
    parameter int T_CD   = 100,
    parameter int T_CC   = 100,
    parameter int T_END  = 10000,
    parameter int T_ERA  = 600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              pgm_clk,
    output logic              pgm_dat_o,
    output logic              pgm_dat_oe,
    input  logic              pgm_dat_i
);
    import pgm_pkg::*;

    localparam int FRAME_W = DATA_W + 2;
    localparam int CW      = $clog2(FRAME_W + 1);
    localparam int TMAX_A  = (T_ERA > T_END) ? T_ERA : T_END;
    localparam int TMAX_B  = (T_CD > T_CC) ? T_CD : T_CC;
    localparam int TMAX    = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW      = $clog2(TMAX + 1);

    st_e                st;
    logic [CMD_W-1:0]   cur_cmd;
    logic [DATA_W-1:0]  cur_dat;
    logic               chain_q;
    logic               sh_start;
    logic               sh_listen;
    logic [CW-1:0]      sh_nbits;
    logic [FRAME_W-1:0] sh_tx;
    logic               sh_done;
    logic [DATA_W-1:0]  sh_rx;
    logic               tm_load;
    logic [TW-1:0]      tm_val;
    logic               tm_done;

    // Wait that follows a command or transfer.
    function automatic logic [TW-1:0] tail_of(input logic [CMD_W-1:0] c);
        if (c == CMD_FINISH_PRG) return TW'(T_END);
        if (c == CMD_BULK_ERASE) return TW'(T_ERA);
        return TW'(T_CC);
    endfunction

    pgm_bit_shifter #(.HALF(HALF), .FRAME_W(FRAME_W), .RX_W(DATA_W)) shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .nbits  (sh_nbits),
        .tx     (sh_tx),
        .listen (sh_listen),
        .dat_i  (pgm_dat_i),
        .done   (sh_done),
        .rx     (sh_rx),
        .sclk   (pgm_clk),
        .dat_o  (pgm_dat_o),
        .dat_oe (pgm_dat_oe)
    );

    pgm_gap_timer #(.TW(TW)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tm_load),
        .val   (tm_val),
        .done  (tm_done)
    );

    // Operation sequencing: command, gap, data, tail wait, optional chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cur_cmd   <= '0;
            cur_dat   <= '0;
            chain_q   <= 1'b0;
            sh_start  <= 1'b0;
            sh_listen <= 1'b0;
            sh_nbits  <= '0;
            sh_tx     <= '0;
            tm_load   <= 1'b0;
            tm_val    <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            sh_start <= 1'b0;
            tm_load  <= 1'b0;
            rd_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        chain_q   <= (req_op == OP_ERASE_CFG);
                        cur_dat   <= (req_op == OP_ERASE_CFG) ? '0 : req_wdata;
                        cur_cmd   <= first_cmd(req_op);
                        sh_start  <= 1'b1;
                        sh_nbits  <= CW'(CMD_W);
                        sh_tx     <= FRAME_W'(first_cmd(req_op));
                        sh_listen <= 1'b0;
                        st        <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (sh_done) begin
                        tm_load <= 1'b1;
                        if (has_data(cur_cmd)) begin
                            tm_val <= TW'(T_CD);
                            st     <= ST_CDGAP;
                        end else begin
                            tm_val <= tail_of(cur_cmd);
                            st     <= ST_TAIL;
                        end
                    end
                end
                ST_CDGAP: begin
                    if (tm_done) begin
                        sh_start  <= 1'b1;
                        sh_nbits  <= CW'(FRAME_W);
                        sh_tx     <= {1'b0, cur_dat, 1'b0};
                        sh_listen <= is_read(cur_cmd);
                        st        <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (sh_done) begin
                        if (is_read(cur_cmd)) begin
                            rd_valid <= 1'b1;
                            rd_data  <= sh_rx;
                        end
                        tm_load <= 1'b1;
                        tm_val  <= TW'(T_CC);
                        st      <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (tm_done) begin
                        if (chain_q) begin
                            chain_q   <= 1'b0;
                            cur_cmd   <= CMD_BULK_ERASE;
                            sh_start  <= 1'b1;
                            sh_nbits  <= CW'(CMD_W);
                            sh_tx     <= FRAME_W'(CMD_BULK_ERASE);
                            sh_listen <= 1'b0;
                            st        <= ST_CMD;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Handshake and status follow the sequencer state.
    always_comb begin
        busy      = (st != ST_IDLE);
        req_ready = (st == ST_IDLE);
    end

endmodule

// File: rtl/pgm_host_seq_chk.sv
// Protocol checker for pgm_host_seq, attached by bind. Observes ports only.
module pgm_host_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic rd_valid,
    input logic pgm_clk,
    input logic pgm_dat_o,
    input logic pgm_dat_oe
);
    a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    a_r10_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    a_r10_idle_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pgm_clk && !pgm_dat_oe && !pgm_dat_o));

    a_r3_data_held_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgm_clk) |-> $stable(pgm_dat_o));

    a_r5_read_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r5_read_strobe_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && !pgm_clk));

    a_r9_not_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);
endmodule

bind pgm_host_seq pgm_host_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .pgm_clk    (pgm_clk),
    .pgm_dat_o  (pgm_dat_o),
    .pgm_dat_oe (pgm_dat_oe)
);

// File: tb/pgm_host_seq_tb.sv
// Bench: target model on the serial lines, directed and random operations.
module pgm_host_seq_tb_top;
    localparam int HALF  = 2;
    localparam int T_CD  = 6;
    localparam int T_CC  = 5;
    localparam int T_END = 30;
    localparam int T_ERA = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [13:0] req_wdata = '0;
    logic        rd_valid;
    logic [13:0] rd_data;
    logic        busy;
    logic        pgm_clk;
    logic        pgm_dat_o;
    logic        pgm_dat_oe;
    logic        pgm_dat_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pgm_host_seq #(.HALF(HALF), .DATA_W(14), .T_CD(T_CD), .T_CC(T_CC),
                   .T_END(T_END), .T_ERA(T_ERA)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .pgm_clk(pgm_clk),
        .pgm_dat_o(pgm_dat_o), .pgm_dat_oe(pgm_dat_oe), .pgm_dat_i(pgm_dat_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected command code and following wait, from the requirement tables.
    function automatic int code_of(input int op);
        case (op)
            0: return 6'b000000;
            1: return 6'b000010;
            2: return 6'b000100;
            3: return 6'b000110;
            4: return 6'b001000;
            5: return 6'b001010;
            default: return 6'b001001;
        endcase
    endfunction

    function automatic int tail_for(input int code);
        if (code == 6'b001010) return T_END;
        if (code == 6'b001001) return T_ERA;
        return T_CC;
    endfunction

    // Target model state.
    int   tst = 0;          // 0 command, 1 load frame, 2 read frame
    int   bitn = 0;
    int   quiet = 0;
    int   min_gap = 0;
    logic prev_clk = 1'b0;
    logic dat_at_rise = 1'b0;
    logic [5:0]  cmd_sh = '0;
    logic [15:0] frm = '0;
    logic [13:0] tgt_word = '0;
    int got_c[$];
    int got_d[$];
    int rd_cnt = 0;
    int rd_last = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                rd_cnt++;
                rd_last = rd_data;
            end
            if (pgm_clk && !prev_clk) begin
                if (bitn == 0) begin
                    if (tst == 0)
                        chk(quiet >= min_gap, (min_gap == T_ERA) ? "R7 gap before next command"
                            : "R6 gap before next command", quiet, min_gap);
                    else
                        chk(quiet >= T_CD, "R4 command-to-data gap", quiet, T_CD);
                end
                if (tst == 2) begin
                    chk(!pgm_dat_oe, "R5 line released in read frame", pgm_dat_oe, 0);
                    pgm_dat_i = (bitn == 0 || bitn == 15) ? 1'b0 : tgt_word[bitn-1];
                end else begin
                    chk(pgm_dat_oe, "R2 host drives command/load", pgm_dat_oe, 1);
                end
                dat_at_rise = pgm_dat_o;
            end
            if (!pgm_clk && prev_clk) begin
                quiet = 0;
                if (tst != 2)
                    chk(pgm_dat_o == dat_at_rise, "R3 data held through pulse", pgm_dat_o, dat_at_rise);
                if (tst == 0) begin
                    cmd_sh[bitn] = pgm_dat_o;
                    bitn++;
                    if (bitn == 6) begin
                        bitn = 0;
                        got_c.push_back(int'(cmd_sh));
                        if (cmd_sh == 6'b000000 || cmd_sh == 6'b000010) tst = 1;
                        else if (cmd_sh == 6'b000100) tst = 2;
                        else min_gap = tail_for(int'(cmd_sh));
                    end
                end else if (tst == 1) begin
                    frm[bitn] = pgm_dat_o;
                    bitn++;
                    if (bitn == 16) begin
                        chk(frm[0] == 1'b0 && frm[15] == 1'b0, "R2 start/stop bits zero",
                            {frm[15], frm[0]}, 0);
                        got_d.push_back(int'(frm[14:1]));
                        bitn = 0; tst = 0; min_gap = T_CC;
                    end
                end else begin
                    bitn++;
                    if (bitn == 16) begin
                        bitn = 0; tst = 0; min_gap = T_CC;
                        pgm_dat_i = 1'b0;
                    end
                end
            end else if (!pgm_clk) begin
                quiet++;
            end
            prev_clk = pgm_clk;
        end
    end

    // Issue one operation and check everything it produced.
    task automatic do_op(input int op, input int wd, input bit noise);
        int exp_c[$];
        int exp_d[$];
        int last_code;
        string tag;
        exp_c.delete(); exp_d.delete();
        if (op == 7) begin
            exp_c.push_back(6'b000000); exp_d.push_back(0); exp_c.push_back(6'b001001);
        end else begin
            exp_c.push_back(code_of(op));
            if (op == 0 || op == 1) exp_d.push_back(wd);
        end
        last_code = exp_c[exp_c.size()-1];
        got_c.delete(); got_d.delete(); rd_cnt = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_wdata = 14'(wd);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R10 busy after accept", busy, 1);
        if (noise) begin
            req_valid = 1'b1; req_op = 3'd3;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (!req_ready) @(negedge clk);
        tag = (op == 7) ? "R8 erase wait" : (op == 6) ? "R7 erase wait" : "R6 tail wait";
        chk(quiet >= tail_for(last_code), tag, quiet, tail_for(last_code));
        tag = (op == 7) ? "R8 command count" : noise ? "R9 command count" : "R1 command count";
        chk(got_c.size() == exp_c.size(), tag, got_c.size(), exp_c.size());
        for (int i = 0; i < exp_c.size() && i < got_c.size(); i++)
            chk(got_c[i] == exp_c[i], (op == 7) ? "R8 command code" : "R1 command code",
                got_c[i], exp_c[i]);
        chk(got_d.size() == exp_d.size(), "R2 data frame count", got_d.size(), exp_d.size());
        for (int i = 0; i < exp_d.size() && i < got_d.size(); i++)
            chk(got_d[i] == exp_d[i], (op == 7) ? "R8 dummy data" : "R2 data value",
                got_d[i], exp_d[i]);
        if (op == 2) begin
            chk(rd_cnt == 1, "R5 one read strobe", rd_cnt, 1);
            chk(rd_last == int'(tgt_word), "R5 read value", rd_last, tgt_word);
        end else begin
            chk(rd_cnt == 0, "R5 no strobe on non-read", rd_cnt, 0);
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0616);
        repeat (4) @(negedge clk);
        chk(!busy && req_ready, "R10 reset idle", {busy, req_ready}, 1);
        chk(!pgm_clk && !pgm_dat_o && !pgm_dat_oe, "R10 reset lines low",
            {pgm_clk, pgm_dat_o, pgm_dat_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corner cases
        do_op(0, 14'h3FFF, 1'b0);
        do_op(1, 14'h0000, 1'b0);
        do_op(1, 14'h2AAA, 1'b1);
        tgt_word = 14'h3FFF; do_op(2, 0, 1'b0);
        tgt_word = 14'h0000; do_op(2, 0, 1'b0);
        tgt_word = 14'h1555; do_op(2, 0, 1'b1);
        do_op(3, 0, 1'b0);
        do_op(4, 0, 1'b0);
        do_op(5, 0, 1'b0);
        do_op(6, 0, 1'b0);
        do_op(7, 14'h3FFF, 1'b1);
        do_op(1, 14'h1234, 1'b0);
        // Random mix
        for (int k = 0; k < 40; k++) begin
            int op;
            op = int'($urandom % 8);
            tgt_word = 14'($urandom);
            do_op(op, int'(14'($urandom)), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule